// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block turns a system clock into a single-cycle bit-rate tick for a serial port. Two stages produce the rate. An integer prescaler divides the clock by (scale + 1). A fractional phase accumulator then adds a step value on each prescaler enable. The output rate is clk / (scale + 1) × step / 2^17. This gives fine rate resolution with no wide divider.

Both values are programmed through one 32-bit configuration word. The scale sits in bits [27:16] and the step sits in bits [15:0]. Writing the word restarts the prescaler and the accumulator, so the new rate begins from a clean phase. The word can be read back at any time.

Top module: `frac_baud_gen`

## Requirements
- R1: Synchronous reset (`rst` high at a rising edge) sets the scale and step to 0 and clears the internal state. After reset, `cfg_rdata` reads 0 and `tick` is low.
- R2: A write (`cfg_we` high at a rising edge) stores bits [27:16] of `cfg_wdata` as the 12-bit scale and bits [15:0] as the 16-bit step. From the next cycle, `cfg_rdata` returns {4'b0000, scale, step}, so bits [31:28] always read 0.
- R3: The prescaler gives one enable every (scale + 1) clocks. `tick` can only be high in the cycle that follows edge W + k·(scale + 1), for k ≥ 1, where W is the edge of the last write.
- R4: Each enable adds the step to a 17-bit phase. The n-th enable after a write raises `tick` exactly when floor(n·step / 2^17) > floor((n−1)·step / 2^17). After n enables, the count of ticks is floor(n·step / 2^17).
- R5: `tick` is never high for two consecutive cycles.
- R6: A write clears the prescaler count and the phase at the same edge. A rewrite in mid-stream restarts the tick pattern from that write.
- R7: A step of 0 produces no ticks.
- R8: A scale of 0 means no prescaling: an enable occurs on every clock.
- R9: Without a write, `cfg_rdata` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word: scale in [27:16], step in [15:0] |
| cfg_rdata | output | 32 | Readback of the configuration word, bits [31:28] zero |
| tick | output | 1 | One-clock bit-rate tick |

## Verification
The assertions assume a few things about the inputs:
- `cfg_we` and `cfg_wdata` are clean, synchronous values at each edge.
- Reset is held for at least one edge before the block's state is used.
- Between writes, the step stays below 2^16. This is what keeps a carry from happening on two enables in a row.

The stimulus keeps within these limits in three ways:
- It drives every input on the falling edge.
- It holds reset for several cycles.
- It only writes 16-bit step values. It sweeps a grid of small scales against step values at 0, at 1, at powers of two, at odd fractions and at the maximum.

After each write, the stimulus compares every cycle against the closed-form tick pattern. It also rewrites the same word in mid-stream.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;
  localparam int CFG_REG_W     = 32;
  localparam int CFG_SCALE_W   = 12;
  localparam int CFG_STEP_W    = 16;
  localparam int CFG_SCALE_LSB = 16;
endpackage

// File: rtl/baud_cfg_reg.sv
module baud_cfg_reg #(
  parameter int REG_W     = 32,
  parameter int SCALE_W   = 12,
  parameter int STEP_W    = 16,
  parameter int SCALE_LSB = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [REG_W-1:0]   wdata,
  output logic [SCALE_W-1:0] scale,
  output logic [STEP_W-1:0]  step,
  output logic [REG_W-1:0]   rdata,
  output logic               clear
);
  localparam int TOP_LSB = SCALE_LSB + SCALE_W;

  function automatic logic [REG_W-1:0] pack_word(logic [SCALE_W-1:0] s,
                                                 logic [STEP_W-1:0] p);
    logic [REG_W-1:0] w;
    w = '0;
    w[STEP_W-1:0] = p;
    w[SCALE_LSB +: SCALE_W] = s;
    return w;
  endfunction

  logic unused_hi;
  assign unused_hi = ^wdata[REG_W-1:TOP_LSB];

  always_ff @(posedge clk) begin
    if (rst) begin
      scale <= '0;
      step  <= '0;
    end else if (we) begin
      scale <= wdata[SCALE_LSB +: SCALE_W];
      step  <= wdata[STEP_W-1:0];
    end
  end

  assign clear = we;
  assign rdata = pack_word(scale, step);

  a_r9_hold_without_write: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(rdata));
endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int SCALE_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic [SCALE_W-1:0] scale,
  output logic               en
);
  logic [SCALE_W-1:0] cnt;

  function automatic logic [SCALE_W-1:0] next_count(logic [SCALE_W-1:0] c,
                                                    logic wrap);
    return wrap ? '0 : c + 1'b1;
  endfunction

  assign en = (cnt == scale);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else            cnt <= next_count(cnt, en);
  end

  a_r3_count_in_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= scale);
  a_r6_clear_count: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));
  a_r3_wrap_restarts: assert property (@(posedge clk) disable iff (rst)
    (en && !clr) |=> (cnt == '0));
endmodule

// File: rtl/baud_phase_acc.sv
module baud_phase_acc #(
  parameter int STEP_W = 16,
  parameter int ACC_W  = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              en,
  input  logic [STEP_W-1:0] step,
  output logic              tick
);
  logic [ACC_W-1:0] acc;
  logic [ACC_W:0]   sum;
  logic             acc_carry;

  function automatic logic [ACC_W:0] phase_add(logic [ACC_W-1:0] a,
                                               logic [STEP_W-1:0] s);
    return {1'b0, a} + {{(ACC_W + 1 - STEP_W){1'b0}}, s};
  endfunction

  assign sum       = phase_add(acc, step);
  assign acc_carry = en & sum[ACC_W];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc  <= '0;
      tick <= 1'b0;
    end else begin
      if (en) acc <= sum[ACC_W-1:0];
      tick <= acc_carry;
    end
  end

  a_r6_clear_phase: assert property (@(posedge clk) disable iff (rst)
    clr |=> (acc == '0 && !tick));
  a_r7_zero_step_idle: assert property (@(posedge clk) disable iff (rst)
    (step == '0 && !clr) |=> ($stable(acc) && !tick));
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import frac_baud_pkg::*;
#(
  parameter int REG_W     = CFG_REG_W,
  parameter int SCALE_W   = CFG_SCALE_W,
  parameter int STEP_W    = CFG_STEP_W,
  parameter int SCALE_LSB = CFG_SCALE_LSB
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  output logic             tick
);
  localparam int ACC_W = STEP_W + 1;

  logic [SCALE_W-1:0] scale;
  logic [STEP_W-1:0]  step;
  logic               cfg_clear;
  logic               pre_en;

  baud_cfg_reg #(
    .REG_W(REG_W), .SCALE_W(SCALE_W), .STEP_W(STEP_W), .SCALE_LSB(SCALE_LSB)
  ) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata),
    .scale(scale), .step(step), .rdata(cfg_rdata), .clear(cfg_clear)
  );

  baud_prescaler #(.SCALE_W(SCALE_W)) u_pre (
    .clk(clk), .rst(rst), .clr(cfg_clear), .scale(scale), .en(pre_en)
  );

  baud_phase_acc #(.STEP_W(STEP_W), .ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst(rst), .clr(cfg_clear), .en(pre_en), .step(step), .tick(tick)
  );

  a_r5_tick_one_wide: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
  a_r3_tick_follows_enable: assert property (@(posedge clk) disable iff (rst)
    tick |-> $past(pre_en));
  a_r2_readback: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (cfg_rdata[REG_W-1:SCALE_LSB+SCALE_W] == '0 &&
                cfg_rdata[SCALE_LSB+SCALE_W-1:0] ==
                $past(cfg_wdata[SCALE_LSB+SCALE_W-1:0])));
endmodule

// File: tb/sim_frac_baud_gen.sv
module sim_frac_baud_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        tick;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  frac_baud_gen u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .tick(tick)
  );

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic write_cfg(int s, int p);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = {4'hA, 12'(s), 16'(p)};
    @(negedge clk);
    cfg_we = 1'b0;
    cfg_wdata = 32'hFFFF_FFFF;
    check("R2 readback", cfg_rdata, {4'h0, 12'(s), 16'(p)});
  endtask

  // Compare every cycle after a write against the closed-form pattern (R3, R4, R8).
  task automatic run_pattern(int s, int p, int len);
    longint n, e;
    int total = 0;
    for (int k = 1; k <= len; k++) begin
      @(posedge clk);
      #1;
      e = 0;
      if (k % (s + 1) == 0) begin
        n = k / (s + 1);
        e = (((n * p) >> 17) != (((n - 1) * p) >> 17)) ? 1 : 0;
      end
      if (tick) total++;
      if (p == 0) check("R7 zero step silent", tick, 0);
      else if (s == 0) check("R8 no prescale pattern", tick, e);
      else check("R3/R4 tick pattern", tick, e);
    end
    n = len / (s + 1);
    check("R4 tick count", total, (n * p) >> 17);
  endtask

  initial begin
    int scales[4] = '{0, 1, 2, 5};
    int steps[7]  = '{0, 1, 16384, 32768, 43690, 40000, 65535};
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset readback", cfg_rdata, 0);
    check("R1 reset tick", tick, 0);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      check("R7 reset step idle", tick, 0);
    end
    foreach (scales[i]) begin
      foreach (steps[j]) begin
        write_cfg(scales[i], steps[j]);
        run_pattern(scales[i], steps[j], 360);
        @(negedge clk);
        check("R9 readback held", cfg_rdata, {4'h0, 12'(scales[i]), 16'(steps[j])});
      end
    end
    // R6: rewrite in mid-stream restarts the pattern
    write_cfg(2, 43690);
    repeat (37) @(posedge clk);
    write_cfg(2, 43690);
    run_pattern(2, 43690, 300);
    write_cfg(1, 65535);
    repeat (5) @(posedge clk);
    write_cfg(3, 32768);
    run_pattern(3, 32768, 200);
    // R1: reset mid-run clears everything
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset readback mid-run", cfg_rdata, 0);
    check("R1 reset tick mid-run", tick, 0);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule